// File: doc/BRIEF.md
# Two-Channel DMA Transfer Termination Controller

This block sequences memory-to-memory transfers for two DMA channels over one shared memory port and decides exactly when each transfer stops. Software programs each channel with a source address, a destination address, a transfer count and a control word. The controller then moves data one unit at a time. Each unit is a read access followed by a write access. In block mode a unit is four read beats followed by as many write beats as the remaining count allows, up to four. The two channels take turns on the port, one unit each.

A channel ends on its own when its count runs out, which raises its end flag and, if enabled, its interrupt line. A channel also stops when software clears its enable bit, and in that case no end flag is raised. Two global flags stop every channel at the next unit boundary. The first is set by a non-maskable event input. The second is set by the controller itself when it issues a misaligned access. Any unit already under way always finishes first, so the channel registers always describe whole completed units. Software restarts the channels by clearing the global flag. A channel whose enable bit is 0 stays idle.

Top module: `dma_end_ctrl`

## Requirements
- R1: After reset every channel register reads 0, both global flags are 0, both interrupt lines are 0 and no memory request is made.
- R2: A word unit reads 4 bytes at the source and writes the same data at the destination. After the unit, source and destination have each advanced by 4 and the count has dropped by 1.
- R3: When a unit brings the count to 0, the end flag (control bit 1) becomes 1 and the channel makes no further accesses. A channel whose count is 0 makes no access even when enabled.
- R4: The channel's interrupt line (irq bit = channel number) is 1 exactly while the end flag and interrupt-enable (control bit 2) are both 1. Writing control bit 1 as 0 clears the end flag and drops the line.
- R5: Writing the enable bit (control bit 0) as 0 lets the unit in progress finish and then stops the channel. The end flag stays 0, and count and addresses reflect only the completed units.
- R6: A pulse on nmi_req sets the event flag (global bit 0). The unit in progress still ends with its write, and no new unit starts on any channel while either global flag is 1.
- R7: An access is misaligned when, in word mode, address bits [1:0] are not 0, or, in block mode (control bit 3), address bits [3:0] are not 0. A misaligned access sets the address-error flag (global bit 1), the rest of the unit (including its writes) completes, and the halt follows. If that unit brought the count to 0, the end flag is also set.
- R8: Writing a global flag bit as 0 clears it. Channels with enable 1, end flag 0 and count not 0 then resume, and a channel with enable 0 stays idle.
- R9: A block unit reads four words from source+0, +4, +8, +12 and then writes min(4, count) words to destination+0, +4, and so on. Afterwards the source has advanced by 16, the destination by 4 per write, and the count has dropped by the number of writes.
- R10: When both channels are eligible, units alternate between the channels.
- R11: Writing 1 to the end flag or to a global flag bit leaves it unchanged.
- R12: While mem_req is 1 and mem_gnt is 0, mem_req, mem_we, mem_addr and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel selected for the write |
| reg_sel | input | 2 | Register selected: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Write data; control bits: 0 enable, 1 end flag, 2 interrupt enable, 3 block mode |
| rd_ch | input | 1 | Channel selected for read-back |
| rd_sel | input | 2 | Register selected for read-back, same coding as reg_sel |
| rd_data | output | 32 | Read-back data (combinational) |
| gfl_we | input | 1 | Global flag write strobe |
| gfl_wdata | input | 2 | Bit 0 event flag, bit 1 address-error flag; 0 clears, 1 keeps |
| nmi_req | input | 1 | Non-maskable event pulse |
| nmi_flag | output | 1 | Event flag |
| ae_flag | output | 1 | Address-error flag |
| irq | output | 2 | Per-channel end-of-transfer interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| mem_gnt | input | 1 | Access completes in a cycle where mem_req and mem_gnt are both 1 |

## Verification
Word transfers with random aligned addresses and counts check the per-unit address and count arithmetic. Block transfers with counts of 1 to 9 separate whole blocks from trimmed final blocks, where the reads stay at four but the writes follow the count. Halts are started by clearing enable, by the event pulse and by a misaligned source, each in the middle of a multi-unit transfer. These cases show whether a stop lands on a unit boundary, whether it leaves the end flag alone, and whether the halted channel resumes only when enabled. Both channels are released together from a global halt to show that units alternate. The memory grant is randomly delayed throughout, so every access is also checked for a stable request while it waits.

// File: rtl/dma_end_pkg.sv
package dma_end_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int NUM_CH    = 2;
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BLK_BEATS = 4;
  localparam int BEAT_W    = $clog2(BLK_BEATS);
  localparam int NWR_W     = BEAT_W + 1;
  localparam int WORD_B    = 4;

  // register select codes
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // control word bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_TE  = 1;
  localparam int CTL_IE  = 2;
  localparam int CTL_BLK = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CH_W-1:0]   ch_t;
  typedef logic [NWR_W-1:0]  nwr_t;

  // alignment rule for the first beat of a unit
  function automatic logic f_misaligned(input addr_t a, input logic blk);
    return blk ? (a[3:0] != 4'd0) : (a[1:0] != 2'd0);
  endfunction

  // destination writes issued by one unit
  function automatic nwr_t f_unit_writes(input cnt_t c, input logic blk);
    if (!blk) return nwr_t'(1);
    if (c >= cnt_t'(BLK_BEATS)) return nwr_t'(BLK_BEATS);
    return nwr_t'(c);
  endfunction

  // source advance per unit: every block reads all beats
  function automatic addr_t f_src_step(input logic blk);
    return blk ? addr_t'(BLK_BEATS * WORD_B) : addr_t'(WORD_B);
  endfunction

  // destination advance per unit follows the writes issued
  function automatic addr_t f_dst_step(input nwr_t n);
    return addr_t'(n) * addr_t'(WORD_B);
  endfunction

  // byte offset of a beat inside a unit
  function automatic addr_t f_beat_off(input logic [BEAT_W-1:0] b);
    return addr_t'(b) * addr_t'(WORD_B);
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_end_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  logic [1:0] sw_sel,
  input  data_t      sw_wdata,
  input  logic       upd_valid,
  input  addr_t      upd_src,
  input  addr_t      upd_dst,
  input  cnt_t       upd_cnt,
  output addr_t      src,
  output addr_t      dst,
  output cnt_t       cnt,
  output logic       en,
  output logic       te,
  output logic       ie,
  output logic       blk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
      en  <= 1'b0;
      te  <= 1'b0;
      ie  <= 1'b0;
      blk <= 1'b0;
    end else begin
      if (sw_we) begin
        case (sw_sel)
          SEL_SRC: src <= addr_t'(sw_wdata);
          SEL_DST: dst <= addr_t'(sw_wdata);
          SEL_CNT: cnt <= sw_wdata[CNT_W-1:0];
          default: begin
            en  <= sw_wdata[CTL_EN];
            ie  <= sw_wdata[CTL_IE];
            blk <= sw_wdata[CTL_BLK];
            if (!sw_wdata[CTL_TE]) te <= 1'b0;
          end
        endcase
      end
      // a completing unit overrides a same-cycle software write
      if (upd_valid) begin
        src <= upd_src;
        dst <= upd_dst;
        cnt <= upd_cnt;
        if (upd_cnt == '0) te <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb
  import dma_end_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] elig,
  input  logic              take,
  output logic              gnt_valid,
  output ch_t               gnt_ch
);
  ch_t last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_ch    = '0;
    for (int i = 1; i <= NUM_CH; i++) begin
      int idx;
      idx = (int'(last_q) + i) % NUM_CH;
      if (!gnt_valid && elig[idx]) begin
        gnt_valid = 1'b1;
        gnt_ch    = ch_t'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= ch_t'(NUM_CH - 1);
    else if (take) last_q <= gnt_ch;
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_end_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  ch_t   start_ch,
  input  addr_t ch_src,
  input  addr_t ch_dst,
  input  cnt_t  ch_cnt,
  input  logic  ch_blk,
  output logic  start_take,
  output logic  unit_done,
  output ch_t   done_ch,
  output addr_t upd_src,
  output addr_t upd_dst,
  output cnt_t  upd_cnt,
  output logic  ae_set,
  output logic  mem_req,
  output logic  mem_we,
  output addr_t mem_addr,
  output data_t mem_wdata,
  input  data_t mem_rdata,
  input  logic  mem_gnt
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE} st_e;

  st_e                st_q;
  ch_t                cur_ch;
  addr_t              cur_src;
  addr_t              cur_dst;
  cnt_t               cur_cnt;
  logic               cur_blk;
  nwr_t               cur_nwr;
  logic [BEAT_W-1:0]  beat_q;
  data_t              buf_q [BLK_BEATS];

  logic [BEAT_W-1:0] last_rd;
  logic              last_wr;
  logic              beat_done;

  assign start_take = (st_q == ST_IDLE) && start;
  assign last_rd    = cur_blk ? BEAT_W'(BLK_BEATS - 1) : '0;
  assign last_wr    = (nwr_t'(beat_q) == cur_nwr - nwr_t'(1));
  assign beat_done  = mem_req && mem_gnt;

  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (mem_we ? cur_dst : cur_src) + f_beat_off(beat_q);
  assign mem_wdata = buf_q[beat_q];

  assign ae_set = beat_done && (beat_q == '0) &&
                  f_misaligned(mem_we ? cur_dst : cur_src, cur_blk);

  assign unit_done = (st_q == ST_DONE);
  assign done_ch   = cur_ch;
  assign upd_src   = cur_src + f_src_step(cur_blk);
  assign upd_dst   = cur_dst + f_dst_step(cur_nwr);
  assign upd_cnt   = cur_cnt - cnt_t'(cur_nwr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_ch  <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
      cur_blk <= 1'b0;
      cur_nwr <= '0;
      beat_q  <= '0;
      for (int i = 0; i < BLK_BEATS; i++) buf_q[i] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          cur_ch  <= start_ch;
          cur_src <= ch_src;
          cur_dst <= ch_dst;
          cur_cnt <= ch_cnt;
          cur_blk <= ch_blk;
          cur_nwr <= f_unit_writes(ch_cnt, ch_blk);
          beat_q  <= '0;
          st_q    <= ST_RD;
        end
        ST_RD: if (mem_gnt) begin
          buf_q[beat_q] <= mem_rdata;
          if (beat_q == last_rd) begin
            beat_q <= '0;
            st_q   <= ST_WR;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_WR: if (mem_gnt) begin
          if (last_wr) st_q <= ST_DONE;
          else beat_q <= beat_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_end_ctrl.sv
module dma_end_ctrl
  import dma_end_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_ch,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        rd_ch,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        gfl_we,
  input  logic [1:0]  gfl_wdata,
  input  logic        nmi_req,
  output logic        nmi_flag,
  output logic        ae_flag,
  output logic [1:0]  irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_gnt
);
  addr_t             ch_src [NUM_CH];
  addr_t             ch_dst [NUM_CH];
  cnt_t              ch_cnt [NUM_CH];
  logic [NUM_CH-1:0] ch_en, ch_te, ch_ie, ch_blk, ch_elig;

  logic  gnt_valid, start_take, unit_done, ae_set;
  ch_t   gnt_ch, done_ch;
  addr_t upd_src, upd_dst;
  cnt_t  upd_cnt;
  logic  halt_all;

  assign halt_all = nmi_flag || ae_flag;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (reg_we && (ch_t'(reg_ch) == ch_t'(c))),
      .sw_sel   (reg_sel),
      .sw_wdata (data_t'(reg_wdata)),
      .upd_valid(unit_done && (done_ch == ch_t'(c))),
      .upd_src  (upd_src),
      .upd_dst  (upd_dst),
      .upd_cnt  (upd_cnt),
      .src      (ch_src[c]),
      .dst      (ch_dst[c]),
      .cnt      (ch_cnt[c]),
      .en       (ch_en[c]),
      .te       (ch_te[c]),
      .ie       (ch_ie[c]),
      .blk      (ch_blk[c])
    );
    assign ch_elig[c] = ch_en[c] && !ch_te[c] && (ch_cnt[c] != '0) && !halt_all;
    assign irq[c]     = ch_te[c] && ch_ie[c];
  end

  dma_rr_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (ch_elig),
    .take     (start_take),
    .gnt_valid(gnt_valid),
    .gnt_ch   (gnt_ch)
  );

  dma_xfer_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (gnt_valid),
    .start_ch  (gnt_ch),
    .ch_src    (ch_src[gnt_ch]),
    .ch_dst    (ch_dst[gnt_ch]),
    .ch_cnt    (ch_cnt[gnt_ch]),
    .ch_blk    (ch_blk[gnt_ch]),
    .start_take(start_take),
    .unit_done (unit_done),
    .done_ch   (done_ch),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_cnt   (upd_cnt),
    .ae_set    (ae_set),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_gnt   (mem_gnt)
  );

  // global halt flags: software clears by writing 0, events set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_flag <= 1'b0;
      ae_flag  <= 1'b0;
    end else begin
      if (gfl_we && !gfl_wdata[0]) nmi_flag <= 1'b0;
      if (gfl_we && !gfl_wdata[1]) ae_flag  <= 1'b0;
      if (nmi_req) nmi_flag <= 1'b1;
      if (ae_set)  ae_flag  <= 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_SRC: rd_data = ch_src[ch_t'(rd_ch)];
      SEL_DST: rd_data = ch_dst[ch_t'(rd_ch)];
      SEL_CNT: rd_data = 32'(ch_cnt[ch_t'(rd_ch)]);
      default: rd_data = {28'd0, ch_blk[rd_ch], ch_ie[rd_ch], ch_te[rd_ch], ch_en[rd_ch]};
    endcase
  end
endmodule

// File: rtl/dma_end_ctrl_chk.sv
module dma_end_ctrl_chk
  import dma_end_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic [31:0]       mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              start_take,
  input ch_t               gnt_ch,
  input logic              nmi_flag,
  input logic              ae_flag,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_te,
  input logic              unit_done,
  input ch_t               done_ch
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R6
  no_start_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |-> !nmi_flag && !ae_flag);

  // R5
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |-> ch_en[gnt_ch] && !ch_te[gnt_ch]);

  // R2
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> $past(mem_req && mem_we && mem_gnt));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_te
    // R3
    te_from_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_te[c]) |-> $past(unit_done && (done_ch == ch_t'(c))));
  end
endmodule

bind dma_end_ctrl dma_end_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .start_take(start_take),
  .gnt_ch    (gnt_ch),
  .nmi_flag  (nmi_flag),
  .ae_flag   (ae_flag),
  .ch_en     (ch_en),
  .ch_te     (ch_te),
  .unit_done (unit_done),
  .done_ch   (done_ch)
);

// File: tb/dma_end_ctrl_bench.sv
`timescale 1ns/1ps
module dma_end_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_ch = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        rd_ch = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        gfl_we = 1'b0;
  logic [1:0]  gfl_wdata = 2'b11;
  logic        nmi_req = 1'b0;
  logic        nmi_flag, ae_flag;
  logic [1:0]  irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_gnt = 1'b0;

  int errs = 0, checks = 0;
  bit finished = 0;

  logic [31:0] bmem [1024];
  logic        log_we   [64];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int          log_n = 0;

  always #4 clk = ~clk;

  dma_end_ctrl u_dma_end_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .gfl_we(gfl_we), .gfl_wdata(gfl_wdata), .nmi_req(nmi_req), .nmi_flag(nmi_flag),
    .ae_flag(ae_flag), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  assign mem_rdata = bmem[mem_addr[11:2]];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction
  function automatic int exp_reads(input int c, input bit blk);
    return blk ? 4 * ((c + 3) / 4) : c;
  endfunction
  function automatic logic [31:0] exp_src_end(input logic [31:0] s, input int c, input bit blk);
    return blk ? s + 32'(16 * ((c + 3) / 4)) : s + 32'(4 * c);
  endfunction

  // random wait before each grant
  always @(negedge clk) mem_gnt = mem_req && (($urandom % 3) != 0);

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (log_n < 64) begin
        log_we[log_n]   = mem_we;
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_wdata;
      end
      log_n = log_n + 1;
      if (mem_we) bmem[mem_addr[11:2]] = mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) bmem[i] = pat(32'(i * 4));
  endtask

  task automatic wr_reg(input logic ch, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic ch, input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_ch = ch; rd_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic wr_gfl(input logic [1:0] d);
    @(negedge clk);
    gfl_we = 1'b1; gfl_wdata = d;
    @(negedge clk);
    gfl_we = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
  endtask

  task automatic setup(input logic ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] c, input logic [31:0] ctl);
    wr_reg(ch, 2'd0, s);
    wr_reg(ch, 2'd1, d);
    wr_reg(ch, 2'd2, c);
    wr_reg(ch, 2'd3, ctl);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int g = 0; g < 5000 && quiet < 10; g++) begin
      @(negedge clk);
      if (mem_req) quiet = 0; else quiet++;
    end
  endtask

  task automatic wait_log(input int n);
    for (int g = 0; g < 5000 && log_n < n; g++) @(negedge clk);
  endtask

  task automatic clr_log();
    @(negedge clk);
    log_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0, d0;
    int w, w1, nr, nw;
    void'($urandom(32'd1234));
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++) begin
        rd_reg(c[0], s[1:0], v);
        chk("R1 register", v, 32'd0);
      end
    chk("R1 flags", {30'd0, ae_flag, nmi_flag}, 32'd0);
    chk("R1 irq", {30'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    // R2 R3 R4 word transfer, ch0, enable+ie
    clr_log();
    setup(1'b0, 32'h100, 32'h200, 32'd3, 32'h5);
    wait_idle();
    chk("R2 access count", 32'(log_n), 32'd6);
    for (int k = 0; k < 3; k++) begin
      chk("R2 read addr", log_addr[2*k], 32'h100 + 32'(4*k));
      chk("R2 write addr", log_addr[2*k+1], 32'h200 + 32'(4*k));
      chk("R2 write data", log_data[2*k+1], pat(32'h100 + 32'(4*k)));
    end
    rd_reg(1'b0, 2'd0, v); chk("R2 src end", v, 32'h10C);
    rd_reg(1'b0, 2'd1, v); chk("R2 dst end", v, 32'h20C);
    rd_reg(1'b0, 2'd2, v); chk("R3 cnt zero", v, 32'd0);
    rd_reg(1'b0, 2'd3, v); chk("R3 end flag set", v, 32'h7);
    chk("R4 irq high", {30'd0, irq}, 32'd1);
    wr_reg(1'b0, 2'd3, 32'h7);
    rd_reg(1'b0, 2'd3, v); chk("R11 end flag write 1 ignored", v, 32'h7);
    clr_log();
    wr_reg(1'b0, 2'd3, 32'h5);
    chk("R4 irq cleared", {30'd0, irq}, 32'd0);
    wait_idle();
    chk("R3 zero count no access", 32'(log_n), 32'd0);
    wr_reg(1'b0, 2'd3, 32'h0);

    // R4 no irq without ie, ch1
    setup(1'b1, 32'h140, 32'h240, 32'd1, 32'h1);
    wait_idle();
    rd_reg(1'b1, 2'd3, v); chk("R3 ch1 end flag", v, 32'h3);
    chk("R4 irq stays low without ie", {30'd0, irq}, 32'd0);
    wr_reg(1'b1, 2'd3, 32'h0);

    // R6 R10 R8 halt then release both channels together
    pulse_nmi();
    chk("R6 event flag set", {31'd0, nmi_flag}, 32'd1);
    clr_log();
    setup(1'b0, 32'h300, 32'h380, 32'd2, 32'h1);
    setup(1'b1, 32'h340, 32'h3C0, 32'd2, 32'h1);
    repeat (10) @(negedge clk);
    chk("R6 no access while halted", 32'(log_n), 32'd0);
    wr_gfl(2'b10);
    wait_idle();
    chk("R8 resumed access count", 32'(log_n), 32'd8);
    for (int k = 0; k < 3; k++)
      chk("R10 alternate channels", {31'd0, log_addr[2*k][6] ^ log_addr[2*k+2][6]}, 32'd1);
    rd_reg(1'b0, 2'd3, v); chk("R3 ch0 done", v, 32'h3);
    rd_reg(1'b1, 2'd3, v); chk("R3 ch1 done", v, 32'h3);
    wr_reg(1'b0, 2'd3, 32'h0);
    wr_reg(1'b1, 2'd3, 32'h0);

    // R5 clearing enable mid-transfer
    clr_log();
    setup(1'b0, 32'h400, 32'h480, 32'd20, 32'h1);
    wait_log(4);
    wr_reg(1'b0, 2'd3, 32'h0);
    wait_idle();
    w = log_n / 2;
    chk("R5 ends on a write", {31'd0, log_we[log_n-1]}, 32'd1);
    chk("R5 stopped early", {31'd0, (w < 20)}, 32'd1);
    rd_reg(1'b0, 2'd2, v); chk("R5 count", v, 32'(20 - w));
    rd_reg(1'b0, 2'd0, v); chk("R5 src", v, 32'h400 + 32'(4*w));
    rd_reg(1'b0, 2'd3, v); chk("R5 end flag stays 0", v, 32'h0);
    rd_reg(1'b0, 2'd2, s0);

    // R6 R11 R8 event halt mid-transfer, ch1
    clr_log();
    setup(1'b1, 32'h500, 32'h580, 32'd10, 32'h1);
    wait_log(3);
    pulse_nmi();
    wait_idle();
    w = log_n / 2;
    chk("R6 flag", {31'd0, nmi_flag}, 32'd1);
    chk("R6 in-flight write completed", {31'd0, log_we[log_n-1]}, 32'd1);
    rd_reg(1'b1, 2'd2, v); chk("R6 count", v, 32'(10 - w));
    rd_reg(1'b1, 2'd1, v); chk("R6 dst", v, 32'h580 + 32'(4*w));
    rd_reg(1'b1, 2'd3, v); chk("R6 end flag 0", v, 32'h1);
    wr_gfl(2'b11);
    chk("R11 flag write 1 ignored", {31'd0, nmi_flag}, 32'd1);
    clr_log();
    repeat (10) @(negedge clk);
    chk("R6 halt holds", 32'(log_n), 32'd0);
    wr_gfl(2'b10);
    wait_idle();
    chk("R8 remaining units", 32'(w + log_n / 2), 32'd10);
    rd_reg(1'b1, 2'd3, v); chk("R8 ch1 finished", v, 32'h3);
    rd_reg(1'b0, 2'd2, v); chk("R8 disabled ch0 idle", v, s0);
    wr_reg(1'b1, 2'd3, 32'h0);

    // R7 misaligned word source
    clr_log();
    setup(1'b0, 32'h602, 32'h680, 32'd4, 32'h1);
    wait_idle();
    chk("R7 ae flag", {31'd0, ae_flag}, 32'd1);
    chk("R7 one unit", 32'(log_n), 32'd2);
    chk("R7 write done", {31'd0, log_we[1]}, 32'd1);
    chk("R7 write addr", log_addr[1], 32'h680);
    rd_reg(1'b0, 2'd2, v); chk("R7 count", v, 32'd3);
    rd_reg(1'b0, 2'd0, v); chk("R7 src", v, 32'h606);
    rd_reg(1'b0, 2'd3, v); chk("R7 end flag 0", v, 32'h1);
    wr_reg(1'b0, 2'd3, 32'h0);
    clr_log();
    wr_gfl(2'b01);
    repeat (10) @(negedge clk);
    chk("R8 ae cleared", {31'd0, ae_flag}, 32'd0);
    chk("R8 disabled stays idle", 32'(log_n), 32'd0);

    // R9 block mode, trimmed final block
    clr_log();
    setup(1'b1, 32'h700, 32'h780, 32'd6, 32'h9);
    wait_idle();
    chk("R9 access count", 32'(log_n), 32'd14);
    nr = 0; nw = 0;
    for (int k = 0; k < log_n && k < 64; k++)
      if (log_we[k]) begin
        chk("R9 write addr", log_addr[k], 32'h780 + 32'(4*nw));
        chk("R9 write data", log_data[k], pat(32'h700 + 32'(4*nw)));
        nw++;
      end else begin
        chk("R9 read addr", log_addr[k], 32'h700 + 32'(4*nr));
        nr++;
      end
    chk("R9 reads", 32'(nr), 32'd8);
    rd_reg(1'b1, 2'd0, v); chk("R9 src", v, 32'h720);
    rd_reg(1'b1, 2'd1, v); chk("R9 dst", v, 32'h798);
    rd_reg(1'b1, 2'd3, v); chk("R9 end flag", v, 32'hB);
    wr_reg(1'b1, 2'd3, 32'h0);

    // R7 misaligned block on final unit
    clr_log();
    setup(1'b0, 32'h808, 32'h880, 32'd4, 32'h9);
    wait_idle();
    chk("R7 block ae", {31'd0, ae_flag}, 32'd1);
    chk("R7 block accesses", 32'(log_n), 32'd8);
    rd_reg(1'b0, 2'd3, v); chk("R7 final unit end flag", v, 32'hB);
    rd_reg(1'b0, 2'd0, v); chk("R7 block src", v, 32'h818);
    wr_reg(1'b0, 2'd3, 32'h0);
    wr_gfl(2'b01);

    // random word and block transfers (R2 R9 R4)
    for (int r = 0; r < 8; r++) begin
      logic ch; bit blk; int c;
      ch  = 1'($urandom % 2);
      blk = 1'($urandom % 2);
      c   = 1 + int'($urandom % 9);
      s0  = 32'(16 * ($urandom % 32));
      d0  = 32'hA00 + 32'(16 * ($urandom % 32));
      init_mem();
      clr_log();
      setup(ch, s0, d0, 32'(c), blk ? 32'hD : 32'h5);
      wait_idle();
      nr = 0; nw = 0;
      for (int k = 0; k < log_n && k < 64; k++)
        if (log_we[k]) begin
          if (log_addr[k] !== d0 + 32'(4*nw) || log_data[k] !== pat(s0 + 32'(4*nw)))
            chk("R2 R9 random write", log_data[k], pat(s0 + 32'(4*nw)));
          nw++;
        end else nr++;
      chk("R2 R9 random writes", 32'(nw), 32'(c));
      chk("R9 random reads", 32'(nr), 32'(exp_reads(c, blk)));
      rd_reg(ch, 2'd0, v); chk("R2 R9 random src", v, exp_src_end(s0, c, blk));
      rd_reg(ch, 2'd1, v); chk("R2 R9 random dst", v, d0 + 32'(4*c));
      chk("R4 random irq", {31'd0, irq[ch]}, 32'd1);
      wr_reg(ch, 2'd3, 32'h0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule